// File: doc/BRIEF.md
# NOR Flash Block Rewrite Sequencer

This engine rewrites one block of flash built from two 16-bit NOR chips that sit side by side on a 32-bit bus. Software supplies a block byte address and a start pulse, and it fills a local source buffer beforehand. The engine then drives one uninterrupted sequence through a memory-mapped master port:

- query the lock state;
- unlock the block only if it is locked;
- erase the block;
- program the block in 32-word buffered chunks;
- lock the block again, even when an earlier step failed.

Every command byte goes to both chips at once, and every ready test needs the flag from both chips. When the sequence ends, the engine raises `done` for one cycle. It leaves `err` and a 3-bit cause code in place until the next start.

The sequence is a single state machine. From S_IDLE, `start` leads to S_ID_CMD and then S_ID_RD. A locked block goes to S_LK_SETUP; an unlocked block goes straight to S_ER_CMD. S_LK_SETUP leads to S_LK_ACT, which issues the unlock or the relock confirm byte. S_ER_CMD leads to S_ER_CONF. Every operation then waits through S_POLL_CMD and S_POLL_RD, looping until both halves report ready. A status error goes through S_CLR; otherwise the engine moves to S_ARRAY.

A phase register decides where S_ARRAY leads:
- after the unlock, to the erase;
- after the erase, to programming, or to the relock if an error was found or the address is misaligned;
- after each chunk, to the next chunk, or to the relock after the last chunk or on an error;
- after the relock, to S_DONE, which returns to S_IDLE.

A chunk runs S_BP_SETUP, then S_BP_RD, which loops back to S_BP_SETUP until the buffer is free, then S_BP_CNT, S_BP_DATA for each word, and S_BP_CONF.

Top module: `nor_block_rewriter`

## Requirements
- R1: Every command and the chunk word count are written with identical upper and lower 16-bit halves. The command bytes are: read-ID 0x90, status 0x70, read-array 0xFF, clear-status 0x50, lock-setup 0x60, unlock or erase or program confirm 0xD0, lock-set 0x01, erase 0x20, buffer request 0xE8.
- R2: Completion is awaited by writing 0x70 and then reading. The loop repeats until bit 7 and bit 23 of the read word are both 1; a word with only one of them set counts as not ready.
- R3: The lock query writes 0x90 to the block address plus 8 and reads the same address. The two halves of the read word are ORed together. Bit 0 of the result set means locked, and only then are 0x60 and 0xD0 written at the block address, before the erase.
- R4: Bit 1 of the folded lock-query word sets `lockdown_warn`; it changes nothing else in the sequence.
- R5: The erase writes 0x20 and then 0xD0. Its status, with each flag taken as the OR of both halves, yields a cause in this priority:
  - VPP (bit 3);
  - sequence, when bits 4, 5, 20 and 21 are all set;
  - erase (bit 5);
  - lock (bit 1).

  A program bit alone is not an erase error.
- R6: The block is programmed in chunks of 32 words at ascending chunk addresses. Each chunk writes the word count minus one (31), then 32 source words at ascending 4-byte addresses, with source index chunk*32+word, then 0xD0.
- R7: Before each chunk, 0xE8 is written and the chunk address is read until bits 7 and 23 are both set. After RETRY_MAX (1000) reads that are not ready, the cause is timeout, read-array is written without clear-status, and programming stops.
- R8: After each chunk, the status yields a cause in this priority: VPP (bit 3), program (bit 4), lock (bit 1). The first failing chunk ends programming.
- R9: Clear-status 0x50 is written exactly once when a status check finds an error, and never otherwise. Every operation ends with 0xFF.
- R10: The block is always relocked with 0x60 then 0x01, also after a failure. `done` is high for one cycle, one cycle after the acknowledge of the final read-array write.
- R11: A block address whose low 7 bits are not zero gives cause align after the erase. No 0xE8 is issued.
- R12: Cause codes are none=0, VPP=1, erase=2, program=3, lock=4, sequence=5, timeout=6, align=7. `err` is high exactly when the cause is not zero. Both hold from `done` until the next accepted start, and a start during a run is ignored.
- R13: A bus request keeps its address, direction and write data stable until the cycle in which `bus_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | begin a rewrite (accepted only when idle) |
| blk_addr | input | AW | byte address of the block |
| done | output | 1 | one-cycle completion pulse |
| err | output | 1 | a failure was found in the last run |
| err_cause | output | 3 | cause code of the last run |
| lockdown_warn | output | 1 | lock query reported locked-down |
| bus_req | output | 1 | bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | bus byte address |
| bus_wdata | output | 32 | bus write data |
| bus_ack | input | 1 | transfer complete; read data valid |
| bus_rdata | input | 32 | bus read data |
| src_idx | output | IW | word index into the source buffer |
| src_data | input | 32 | source word at src_idx, same cycle |

## Verification
Directed runs set the lock-query word and the status words so that several flags appear together. This confirms that the priority order, not merely the presence of a flag, picks the cause. A status word with a program bit but no erase flags must not fail the erase. Further runs hold one half ready while the other is busy, keep one chunk's buffer busy past the retry limit, and use a misaligned block address. These separate correct two-half tests from single-half tests, exact retry counting from off-by-one counting, and an early exit with relock from a run that falls through. Seeded random runs mix lock states, poll delays, bus wait states and random error bits, and their expected cause, chunk count and array contents come from bench functions.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_VPP     = 3'd1,
        CAUSE_ERASE   = 3'd2,
        CAUSE_PROG    = 3'd3,
        CAUSE_LOCK    = 3'd4,
        CAUSE_SEQ     = 3'd5,
        CAUSE_TIMEOUT = 3'd6,
        CAUSE_ALIGN   = 3'd7
    } cause_e;

    typedef enum logic [4:0] {
        S_IDLE, S_ID_CMD, S_ID_RD, S_LK_SETUP, S_LK_ACT,
        S_ER_CMD, S_ER_CONF, S_POLL_CMD, S_POLL_RD, S_CLR,
        S_ARRAY, S_BP_SETUP, S_BP_RD, S_BP_CNT, S_BP_DATA,
        S_BP_CONF, S_DONE
    } state_e;

    typedef enum logic [1:0] {
        PH_UNLOCK, PH_ERASE, PH_PROG, PH_RELOCK
    } phase_e;

    localparam logic [15:0] OP_READ_ID    = 16'h0090;
    localparam logic [15:0] OP_STATUS     = 16'h0070;
    localparam logic [15:0] OP_ARRAY      = 16'h00FF;
    localparam logic [15:0] OP_CLEAR      = 16'h0050;
    localparam logic [15:0] OP_LOCK_SETUP = 16'h0060;
    localparam logic [15:0] OP_CONFIRM    = 16'h00D0;
    localparam logic [15:0] OP_LOCK_SET   = 16'h0001;
    localparam logic [15:0] OP_ERASE      = 16'h0020;
    localparam logic [15:0] OP_BUF_REQ    = 16'h00E8;

    function automatic logic [31:0] both_halves(input logic [15:0] v);
        return {v, v};
    endfunction

endpackage

// File: rtl/nor_status_eval.sv
module nor_status_eval
    import nor_seq_pkg::*;
(
    input  logic [31:0] word,
    output logic        ready,
    output logic        locked,
    output logic        lockdown,
    output cause_e      erase_cause,
    output cause_e      prog_cause
);
    logic [15:0] fold;
    logic        f_vpp, f_erase, f_prog, f_lock, f_seq;

    always_comb begin
        fold     = word[31:16] | word[15:0];
        ready    = word[7] & word[23];
        locked   = fold[0];
        lockdown = fold[1];
        f_vpp    = fold[3];
        f_erase  = fold[5];
        f_prog   = fold[4];
        f_lock   = fold[1];
        f_seq    = word[4] & word[5] & word[20] & word[21];

        if (f_vpp)        erase_cause = CAUSE_VPP;
        else if (f_seq)   erase_cause = CAUSE_SEQ;
        else if (f_erase) erase_cause = CAUSE_ERASE;
        else if (f_lock)  erase_cause = CAUSE_LOCK;
        else              erase_cause = CAUSE_NONE;

        if (f_vpp)        prog_cause = CAUSE_VPP;
        else if (f_prog)  prog_cause = CAUSE_PROG;
        else if (f_lock)  prog_cause = CAUSE_LOCK;
        else              prog_cause = CAUSE_NONE;
    end
endmodule

// File: rtl/nor_prog_cursor.sv
module nor_prog_cursor #(
    parameter int NCHUNK      = 4,
    parameter int CHUNK_WORDS = 32,
    localparam int KW = (NCHUNK > 1) ? $clog2(NCHUNK) : 1,
    localparam int WW = (CHUNK_WORDS > 1) ? $clog2(CHUNK_WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          word_step,
    input  logic          chunk_step,
    output logic [KW-1:0] chunk,
    output logic [WW-1:0] word,
    output logic          last_word,
    output logic          last_chunk
);
    assign last_word  = (word == WW'(CHUNK_WORDS - 1));
    assign last_chunk = (chunk == KW'(NCHUNK - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chunk <= '0;
            word  <= '0;
        end else if (clear) begin
            chunk <= '0;
            word  <= '0;
        end else begin
            if (chunk_step) begin
                chunk <= chunk + 1'b1;
                word  <= '0;
            end else if (word_step) begin
                word <= last_word ? '0 : word + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nor_retry_ctr.sv
module nor_retry_ctr #(
    parameter int LIMIT = 1000,
    localparam int W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    logic [W-1:0] cnt;

    assign last = (cnt == W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (step)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/nor_block_rewriter.sv
module nor_block_rewriter
    import nor_seq_pkg::*;
#(
    parameter int AW          = 32,
    parameter int BLOCK_BYTES = 512,
    parameter int CHUNK_WORDS = 32,
    parameter int RETRY_MAX   = 1000,
    localparam int IW = $clog2(BLOCK_BYTES / 4)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] blk_addr,
    output logic          done,
    output logic          err,
    output logic [2:0]    err_cause,
    output logic          lockdown_warn,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [31:0]   bus_wdata,
    input  logic          bus_ack,
    input  logic [31:0]   bus_rdata,
    output logic [IW-1:0] src_idx,
    input  logic [31:0]   src_data
);
    localparam int CHUNK_BYTES = CHUNK_WORDS * 4;
    localparam int NCHUNK      = BLOCK_BYTES / CHUNK_BYTES;
    localparam int CB_LOG      = $clog2(CHUNK_BYTES);
    localparam int KW          = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
    localparam int WW          = (CHUNK_WORDS > 1) ? $clog2(CHUNK_WORDS) : 1;
    localparam logic [AW-1:0] ID_OFS = AW'(8);

    state_e  state;
    phase_e  phase;
    cause_e  cause_r;
    logic    err_r, warn_r;
    logic [AW-1:0] blk_q;

    logic    st_ready, st_locked, st_lockdown;
    cause_e  erase_cause, prog_cause;
    logic [KW-1:0] chunk;
    logic [WW-1:0] word;
    logic    last_word, last_chunk, retry_last;
    logic    cur_clear, chunk_step, word_step, retry_clear, retry_step;
    logic    aligned;
    logic [AW-1:0] chunk_addr, data_addr;

    nor_status_eval u_eval (
        .word        (bus_rdata),
        .ready       (st_ready),
        .locked      (st_locked),
        .lockdown    (st_lockdown),
        .erase_cause (erase_cause),
        .prog_cause  (prog_cause)
    );

    nor_prog_cursor #(.NCHUNK(NCHUNK), .CHUNK_WORDS(CHUNK_WORDS)) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (cur_clear),
        .word_step  (word_step),
        .chunk_step (chunk_step),
        .chunk      (chunk),
        .word       (word),
        .last_word  (last_word),
        .last_chunk (last_chunk)
    );

    nor_retry_ctr #(.LIMIT(RETRY_MAX)) u_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (retry_clear),
        .step  (retry_step),
        .last  (retry_last)
    );

    always_comb begin
        aligned     = (blk_q[CB_LOG-1:0] == '0);
        chunk_addr  = blk_q + (AW'(chunk) << CB_LOG);
        data_addr   = chunk_addr + (AW'(word) << 2);
        cur_clear   = (state == S_ARRAY) && bus_ack && (phase == PH_ERASE);
        chunk_step  = (state == S_ARRAY) && bus_ack && (phase == PH_PROG)
                      && !err_r && !last_chunk;
        word_step   = (state == S_BP_DATA) && bus_ack;
        retry_clear = (state == S_ARRAY);
        retry_step  = (state == S_BP_RD) && bus_ack && !st_ready && !retry_last;
        src_idx     = (IW'(chunk) << WW) | IW'(word);
    end

    // State register and run flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            phase   <= PH_UNLOCK;
            cause_r <= CAUSE_NONE;
            err_r   <= 1'b0;
            warn_r  <= 1'b0;
            blk_q   <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    blk_q   <= blk_addr;
                    cause_r <= CAUSE_NONE;
                    err_r   <= 1'b0;
                    warn_r  <= 1'b0;
                    state   <= S_ID_CMD;
                end
                S_ID_CMD: if (bus_ack) state <= S_ID_RD;
                S_ID_RD: if (bus_ack) begin
                    warn_r <= st_lockdown;
                    if (st_locked) begin
                        phase <= PH_UNLOCK;
                        state <= S_LK_SETUP;
                    end else begin
                        phase <= PH_ERASE;
                        state <= S_ER_CMD;
                    end
                end
                S_LK_SETUP: if (bus_ack) state <= S_LK_ACT;
                S_LK_ACT:   if (bus_ack) state <= S_POLL_CMD;
                S_ER_CMD:   if (bus_ack) state <= S_ER_CONF;
                S_ER_CONF:  if (bus_ack) state <= S_POLL_CMD;
                S_POLL_CMD: if (bus_ack) state <= S_POLL_RD;
                S_POLL_RD: if (bus_ack) begin
                    if (!st_ready) begin
                        state <= S_POLL_CMD;
                    end else if (phase == PH_ERASE && erase_cause != CAUSE_NONE) begin
                        cause_r <= erase_cause;
                        err_r   <= 1'b1;
                        state   <= S_CLR;
                    end else if (phase == PH_PROG && prog_cause != CAUSE_NONE) begin
                        cause_r <= prog_cause;
                        err_r   <= 1'b1;
                        state   <= S_CLR;
                    end else begin
                        state <= S_ARRAY;
                    end
                end
                S_CLR: if (bus_ack) state <= S_ARRAY;
                S_ARRAY: if (bus_ack) begin
                    unique case (phase)
                        PH_UNLOCK: begin
                            phase <= PH_ERASE;
                            state <= S_ER_CMD;
                        end
                        PH_ERASE: begin
                            if (err_r) begin
                                phase <= PH_RELOCK;
                                state <= S_LK_SETUP;
                            end else if (!aligned) begin
                                cause_r <= CAUSE_ALIGN;
                                err_r   <= 1'b1;
                                phase   <= PH_RELOCK;
                                state   <= S_LK_SETUP;
                            end else begin
                                phase <= PH_PROG;
                                state <= S_BP_SETUP;
                            end
                        end
                        PH_PROG: begin
                            if (err_r || last_chunk) begin
                                phase <= PH_RELOCK;
                                state <= S_LK_SETUP;
                            end else begin
                                state <= S_BP_SETUP;
                            end
                        end
                        PH_RELOCK: state <= S_DONE;
                        default:   state <= S_DONE;
                    endcase
                end
                S_BP_SETUP: if (bus_ack) state <= S_BP_RD;
                S_BP_RD: if (bus_ack) begin
                    if (st_ready) begin
                        state <= S_BP_CNT;
                    end else if (retry_last) begin
                        cause_r <= CAUSE_TIMEOUT;
                        err_r   <= 1'b1;
                        state   <= S_ARRAY;
                    end else begin
                        state <= S_BP_SETUP;
                    end
                end
                S_BP_CNT:  if (bus_ack) state <= S_BP_DATA;
                S_BP_DATA: if (bus_ack && last_word) state <= S_BP_CONF;
                S_BP_CONF: if (bus_ack) state <= S_POLL_CMD;
                S_DONE:    state <= S_IDLE;
                default:   state <= S_IDLE;
            endcase
        end
    end

    // Output decode
    always_comb begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = blk_q;
        bus_wdata = both_halves(OP_ARRAY);
        unique case (state)
            S_IDLE, S_DONE: begin
                bus_req = 1'b0;
                bus_we  = 1'b0;
            end
            S_ID_CMD: begin
                bus_addr  = blk_q + ID_OFS;
                bus_wdata = both_halves(OP_READ_ID);
            end
            S_ID_RD: begin
                bus_we   = 1'b0;
                bus_addr = blk_q + ID_OFS;
            end
            S_LK_SETUP: bus_wdata = both_halves(OP_LOCK_SETUP);
            S_LK_ACT:   bus_wdata = (phase == PH_RELOCK) ? both_halves(OP_LOCK_SET)
                                                         : both_halves(OP_CONFIRM);
            S_ER_CMD:   bus_wdata = both_halves(OP_ERASE);
            S_ER_CONF:  bus_wdata = both_halves(OP_CONFIRM);
            S_POLL_CMD: bus_wdata = both_halves(OP_STATUS);
            S_POLL_RD:  bus_we    = 1'b0;
            S_CLR:      bus_wdata = both_halves(OP_CLEAR);
            S_ARRAY:    bus_wdata = both_halves(OP_ARRAY);
            S_BP_SETUP: begin
                bus_addr  = chunk_addr;
                bus_wdata = both_halves(OP_BUF_REQ);
            end
            S_BP_RD: begin
                bus_we   = 1'b0;
                bus_addr = chunk_addr;
            end
            S_BP_CNT: begin
                bus_addr  = chunk_addr;
                bus_wdata = both_halves(16'(CHUNK_WORDS - 1));
            end
            S_BP_DATA: begin
                bus_addr  = data_addr;
                bus_wdata = src_data;
            end
            S_BP_CONF: bus_wdata = both_halves(OP_CONFIRM);
            default: begin
                bus_req = 1'b0;
                bus_we  = 1'b0;
            end
        endcase
        done          = (state == S_DONE);
        err           = err_r;
        err_cause     = cause_r;
        lockdown_warn = warn_r;
    end
endmodule

// File: rtl/nor_block_rewriter_checker.sv
module nor_block_rewriter_checker
    import nor_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input state_e        state,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          bus_ack,
    input logic          done,
    input logic          err,
    input logic [2:0]    err_cause
);
    p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_wdata)));

    p_cmd_halves_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && state != S_BP_DATA) |-> (bus_wdata[31:16] == bus_wdata[15:0]));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_array_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state) == S_ARRAY && $past(bus_ack)));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !bus_req);

    p_err_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_cause != 3'd0));
endmodule

bind nor_block_rewriter nor_block_rewriter_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .done      (done),
    .err       (err),
    .err_cause (err_cause)
);

// File: tb/nor_block_rewriter_bench.sv
module nor_block_rewriter_bench;
    localparam int NW = 128, NCH = 4, CWD = 32, RETRY = 1000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, start, done, err, lockdown_warn, bus_req, bus_we, bus_ack;
    logic [2:0]  err_cause;
    logic [31:0] blk_addr, bus_addr, bus_wdata, bus_rdata, src_data;
    logic [6:0]  src_idx;
    logic [31:0] src_mem [NW];
    assign src_data = src_mem[src_idx];

    nor_block_rewriter u_nor_block_rewriter (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr),
        .done(done), .err(err), .err_cause(err_cause), .lockdown_warn(lockdown_warn),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .src_idx(src_idx), .src_data(src_data)
    );

    int n_chk = 0, n_bad = 0;
    bit hung = 0;

    // flash pair model state
    int cyc = 0, done_cyc = 0, last_ff_cyc = 0;
    logic [31:0] mem [NW];
    bit locked_m, lockdown_m;
    int erase_cnt, unlock_cnt, relock_cnt, clr_cnt, e8_cnt, conf_cnt;
    int dup_bad, order_bad, count_bad, addr_bad, hold_bad;
    int mode, stage, poll_left, poll_busy, wr_idx, wr_left, chunk_base, chunk_no;
    int wait_left = -1;
    bit held = 0;
    logic [31:0] held_addr, held_data, sr, base_m, inj_erase, inj_prog;
    int inj_chunk, busy_chunk;

    localparam logic [31:0] RDY = 32'h0080_0080;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < NW; i++) mem[i] = 32'h1234_0000 + i;
        erase_cnt = 0; unlock_cnt = 0; relock_cnt = 0; clr_cnt = 0; e8_cnt = 0;
        conf_cnt = 0; dup_bad = 0; order_bad = 0; count_bad = 0; addr_bad = 0;
        hold_bad = 0; mode = 0; stage = 0; sr = RDY; poll_left = 0; chunk_no = 0;
        done_cyc = 0; last_ff_cyc = 0;
    endtask

    task automatic model_write();
        logic [31:0] off;
        logic [7:0] cmd;
        off = bus_addr - base_m;
        cmd = bus_wdata[7:0];
        if (stage != 4 && bus_wdata[31:16] != bus_wdata[15:0]) dup_bad++;
        if (off >= 32'd512) addr_bad++;
        case (stage)
            3: begin
                if (bus_wdata[15:0] != 16'(CWD - 1)) count_bad++;
                wr_left = int'(bus_wdata[15:0]) + 1; wr_idx = 0;
                chunk_base = int'(off >> 2); stage = 4;
            end
            4: begin
                if (int'(off >> 2) != chunk_base + wr_idx) order_bad++;
                if (off < 32'd512) mem[off >> 2] = bus_wdata;
                wr_idx++;
                if (wr_idx == wr_left) stage = 5;
            end
            5: begin
                if (cmd == 8'hD0) begin
                    sr = RDY | ((chunk_no == inj_chunk) ? inj_prog : 32'h0);
                    chunk_no++; conf_cnt++;
                end
                stage = 0; mode = 1; poll_left = poll_busy;
            end
            1: begin
                if (cmd == 8'hD0) begin locked_m = 0; unlock_cnt++; end
                if (cmd == 8'h01) begin locked_m = 1; relock_cnt++; end
                sr = RDY; stage = 0; mode = 1; poll_left = poll_busy;
            end
            2: begin
                if (cmd == 8'hD0) begin
                    for (int i = 0; i < NW; i++) mem[i] = 32'hFFFF_FFFF;
                    erase_cnt++; sr = RDY | inj_erase;
                end
                stage = 0; mode = 1; poll_left = poll_busy;
            end
            default: begin
                case (cmd)
                    8'h90: mode = 2;
                    8'h70: mode = 1;
                    8'hFF: begin mode = 0; last_ff_cyc = cyc; end
                    8'h50: begin sr = RDY; clr_cnt++; end
                    8'h60: stage = 1;
                    8'h20: stage = 2;
                    8'hE8: begin mode = 3; e8_cnt++; end
                    default: ;
                endcase
            end
        endcase
    endtask

    task automatic model_read();
        logic [31:0] off;
        off = bus_addr - base_m;
        case (mode)
            1: begin
                if (poll_left > 0) begin poll_left--; bus_rdata = 32'h0000_0080; end
                else bus_rdata = sr;
            end
            2: begin
                if (off != 32'd8) addr_bad++;
                bus_rdata = {15'b0, locked_m, 14'b0, lockdown_m, 1'b0};
            end
            3: begin
                if (chunk_no == busy_chunk) bus_rdata = 32'h0080_0000;
                else begin bus_rdata = RDY; stage = 3; end
            end
            default: bus_rdata = (off < 32'd512) ? mem[off >> 2] : 32'h0;
        endcase
    endtask

    initial begin
        bus_ack = 1'b0; bus_rdata = 32'h0;
        forever begin
            @(negedge clk);
            cyc++;
            if (done) done_cyc = cyc;
            if (bus_ack) bus_ack = 1'b0;
            else if (bus_req && rst_n) begin
                if (held && (bus_addr != held_addr || bus_wdata != held_data)) hold_bad++;
                if (wait_left < 0) wait_left = int'($urandom % 2);
                if (wait_left > 0) begin
                    wait_left--; held = 1; held_addr = bus_addr; held_data = bus_wdata;
                end else begin
                    wait_left = -1; held = 0;
                    if (bus_we) model_write(); else model_read();
                    bus_ack = 1'b1;
                end
            end
        end
    end

    function automatic int erase_code(input logic [31:0] s);
        logic [15:0] f;
        f = s[31:16] | s[15:0];
        if (f[3]) return 1;
        if ((s & 32'h0030_0030) == 32'h0030_0030) return 5;
        if (f[5]) return 2;
        if (f[1]) return 4;
        return 0;
    endfunction

    function automatic int prog_code(input logic [31:0] s);
        logic [15:0] f;
        f = s[31:16] | s[15:0];
        if (f[3]) return 1;
        if (f[4]) return 3;
        if (f[1]) return 4;
        return 0;
    endfunction

    task automatic run_case(input logic [31:0] base, input bit lk, input bit ld,
                            input int polls, input logic [31:0] esr, input logic [31:0] psr,
                            input int pchunk, input int bchunk, input bit restart);
        int ecause, echunks, ee8, pc;
        bit got;
        bit mis;
        if (hung) return;
        mis = (base[6:0] != 7'd0);
        ecause = erase_code(esr); echunks = 0; ee8 = 0;
        if (ecause == 0 && mis) ecause = 7;
        else if (ecause == 0) begin
            for (int c = 0; c < NCH; c++) begin
                if (c == bchunk) begin ecause = 6; ee8 += RETRY; break; end
                ee8++; echunks++;
                pc = (c == pchunk) ? prog_code(psr) : 0;
                if (pc != 0) begin ecause = pc; break; end
            end
        end
        for (int i = 0; i < NW; i++) src_mem[i] = $urandom;
        model_clear();
        base_m = base; locked_m = lk; lockdown_m = ld; poll_busy = polls;
        inj_erase = esr; inj_prog = psr; inj_chunk = pchunk; busy_chunk = bchunk;
        @(negedge clk); blk_addr = base; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (restart) begin
            repeat (30) @(negedge clk);
            blk_addr = base + 32'h1000; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        got = 0;
        for (int w = 0; w < 30000; w++) begin
            @(negedge clk);
            if (done) begin got = 1; break; end
        end
        if (!got) begin
            hung = 1;
            chk(0, "R10", "watchdog: done never seen", 0, 1);
            return;
        end
        repeat (3) @(negedge clk);
        chk(err_cause == 3'(ecause), "R12", "cause code", int'(err_cause), ecause);
        chk(err == (ecause != 0), "R12", "err flag held", int'(err), int'(ecause != 0));
        chk(lockdown_warn == ld, "R4", "lockdown warn", int'(lockdown_warn), int'(ld));
        chk(unlock_cnt == int'(lk), "R3", "unlock count", unlock_cnt, int'(lk));
        chk(relock_cnt == 1 && locked_m, "R10", "relock count", relock_cnt, 1);
        chk(done_cyc == last_ff_cyc + 1, "R10", "done timing", done_cyc, last_ff_cyc + 1);
        chk(erase_cnt == 1, "R5", "erase count", erase_cnt, 1);
        chk(clr_cnt == ((ecause >= 1 && ecause <= 5) ? 1 : 0), "R9", "clear-status count",
            clr_cnt, (ecause >= 1 && ecause <= 5) ? 1 : 0);
        chk(conf_cnt == echunks, "R8", "chunks programmed", conf_cnt, echunks);
        chk(e8_cnt == ee8, mis ? "R11" : "R7", "buffer requests", e8_cnt, ee8);
        chk(dup_bad == 0, "R1", "command halves differ", dup_bad, 0);
        chk(order_bad == 0 && count_bad == 0, "R6", "chunk order/count", order_bad + count_bad, 0);
        chk(addr_bad == 0, "R12", "stray address", addr_bad, 0);
        chk(hold_bad == 0, "R13", "request changed before ack", hold_bad, 0);
        begin
            int bad = 0;
            for (int i = 0; i < NW; i++)
                if (mem[i] != (((i / CWD) < echunks) ? src_mem[i] : 32'hFFFF_FFFF)) bad++;
            chk(bad == 0, "R6", "array words wrong", bad, 0);
        end
    endtask

    initial begin
        logic [31:0] es, ps;
        rst_n = 1'b0; start = 1'b0; blk_addr = 32'h0;
        base_m = 32'h0; inj_chunk = -1; busy_chunk = -1; poll_busy = 0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(!done && !err && !bus_req && err_cause == 3'd0, "R12", "reset state",
            int'({done, err, bus_req}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // directed corners
        run_case(32'h0001_0000, 0, 0, 0, 32'h0, 32'h0, -1, -1, 0);          // R6 clean
        run_case(32'h0001_0200, 1, 1, 2, 32'h0, 32'h0, -1, -1, 1);          // R2 R3 R4 restart
        run_case(32'h0001_0400, 0, 0, 1, 32'h0000_0008, 32'h0, -1, -1, 0);  // R5 vpp one half
        run_case(32'h0001_0600, 0, 0, 0, 32'h0030_0030, 32'h0, -1, -1, 0);  // R5 sequence
        run_case(32'h0001_0800, 1, 0, 0, 32'h0022_0000, 32'h0, -1, -1, 0);  // R5 erase > lock
        run_case(32'h0001_0A00, 0, 0, 0, 32'h0010_0000, 32'h0, -1, -1, 0);  // R5 prog bit alone
        run_case(32'h0001_0C00, 0, 1, 1, 32'h0, 32'h0002_0010, 2, -1, 0);   // R8 prog > lock
        run_case(32'h0001_0E00, 1, 0, 0, 32'h0, 32'h0008_0002, 0, -1, 0);   // R8 vpp first chunk
        run_case(32'h0001_1000, 0, 0, 0, 32'h0, 32'h0, -1, 1, 0);           // R7 timeout
        run_case(32'h0001_1240, 1, 0, 0, 32'h0, 32'h0, -1, -1, 0);          // R11 misaligned
        // seeded random mix
        for (int k = 0; k < 8; k++) begin
            es = ($urandom % 3 == 0) ? ($urandom & 32'h003A_003A) : 32'h0;
            ps = ($urandom % 2 == 0) ? ($urandom & 32'h001A_001A) : 32'h0;
            run_case(32'h0002_0000 + 32'(k) * 32'h200, 1'($urandom), 1'($urandom),
                     int'($urandom % 3), es, ps, int'($urandom % NCH),
                     ($urandom % 8 == 0) ? int'($urandom % NCH) : -1, 0);
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule